// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block runs external memory cycles for a microcontroller core over a 16-bit bus that carries the address and the data on the same lines. The core presents one request at a time: a read or write, a 16-bit address, a byte or word size, a flag that marks a read as an instruction fetch, and write data. The block first decides from the address whether the access leaves the chip. If it does not, the request completes one cycle later and is flagged as local. If it does, the block runs a bus cycle. The cycle has an address phase, a strobe phase, optional wait phases and a release phase. It then returns read data to the core, taken from the lane that the address selects.

Three configuration inputs give the bus pins their behaviour, and the block latches them while it is idle. The first selects whether the address strobe pin is a one-cycle latch pulse or an active-low valid level that lasts the whole cycle. The second selects one write strobe for every write, or separate low-byte and high-byte write strobes. The same bit decides whether the shared pin acts as an active-low high-byte enable or as the high-byte write strobe. A ready input stretches the strobe, and a wait limit caps how many wait phases a cycle may insert. Ready is sampled at each clock edge that ends a strobe or wait phase. One clock of the block stands for one period of the clock output.

Top module: `xbus_seq`

## Requirements
- R1: After reset, rd_n, wr_lo_n and bhe_wrh_n are 1. inst, ad_oe, done and done_local are 0. addr_strb is 0 (latch mode), req_rdy is 1 and rdata is 0.
- R2: An off-chip request is accepted at a clock edge where req_valid is 1 in idle. The cycle that follows lasts 3 + W clocks, where W is the number of wait phases: address, strobe, W waits, release. done is 1 only in the release clock. With cfg_adv_mode=0, addr_strb is 1 for the address clock alone.
- R3: With cfg_adv_mode=1, addr_strb is active low. It is 0 from the address clock through the last strobe or wait clock (2 + W clocks) and 1 in release and idle.
- R4: A read drives rd_n low in the strobe and wait clocks only, and ad_oe is 0 after the address clock. Data is taken from ad_in at the edge that ends the last strobe or wait clock. A word returns ad_in. A byte at an even address returns ad_in[7:0] zero-extended, and a byte at an odd address returns ad_in[15:8] zero-extended.
- R5: In the address clock, ad_out[0] carries A0: 0 for a word, the address bit 0 for a byte. With cfg_split_wr=0, bhe_wrh_n is 0 from address through release when the high lane is used (word, or a byte at an odd address), and 1 otherwise.
- R6: With cfg_split_wr=0, wr_lo_n is low in every strobe and wait clock of every write, whatever the size.
- R7: With cfg_split_wr=1, wr_lo_n is low in strobe and wait clocks only when the low lane is written (word or even byte). bhe_wrh_n is low in those clocks only when the high lane is written (word or odd byte).
- R8: In a write, ad_oe is 1 and ad_out holds the write data from the strobe clock through release. A byte write repeats wdata[7:0] on both lanes.
- R9: inst equals 1 in every clock of an off-chip read with req_fetch=1, from address through release. It is 0 for data reads, for writes and while idle.
- R10: If bus_rdy is 0 at the edge ending a strobe or wait clock and the wait count is below the limit, another wait clock follows. If bus_rdy is 1, the release clock follows.
- R11: A cycle inserts at most cfg_wait_lim wait clocks. It then enters release even while bus_rdy stays 0.
- R12: While no bus cycle is in progress, bus_rdy has no effect: no strobe, rd_n, inst or ad_oe activity occurs.
- R13: Addresses below 2000h are local. Addresses 2000h to 3FFFh are off-chip only when ext_sel_n is 0. Addresses from 4000h up are always off-chip. A local request sets done and done_local for the one clock after acceptance, with no bus pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per bus phase |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken while req_rdy is 1 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_word | input | 1 | 1 for 16-bit access, 0 for byte |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_rdy | output | 1 | Block idle and able to take a request |
| done | output | 1 | Request complete this clock |
| done_local | output | 1 | Completed request was local |
| rdata | output | 16 | Read data, zero-extended for bytes |
| cfg_adv_mode | input | 1 | 0 latch pulse, 1 cycle-long active-low valid |
| cfg_split_wr | input | 1 | 0 single write strobe with byte-high enable, 1 per-lane write strobes |
| cfg_wait_lim | input | 2 | Maximum wait clocks per cycle |
| ext_sel_n | input | 1 | 0 routes 2000h-3FFFh off-chip |
| bus_rdy | input | 1 | Bus ready; 0 stretches the strobe |
| ad_in | input | 16 | Bus value read from the pads |
| ad_out | output | 16 | Address, then write data, to the pads |
| ad_oe | output | 1 | Pad output enable for ad_out |
| addr_strb | output | 1 | Address latch pulse or active-low address valid |
| rd_n | output | 1 | Active-low read strobe |
| wr_lo_n | output | 1 | Active-low write, or low-lane write |
| bhe_wrh_n | output | 1 | Active-low high-byte enable, or high-lane write |
| inst | output | 1 | Instruction-fetch indicator |

## Verification
The checker watches every clock for the phase order and the ready rules. It checks that address is followed by strobe, that a low ready below the limit yields a wait and a high ready yields release, and that the wait count never passes the latched limit. On every clock it also checks that the latch pulse lasts one clock and that the valid level covers strobe and wait. It checks that rd_n only falls in reads, that inst does not change within a cycle, that write data is driven, and that idle or local completions leave the bus quiet. The bench scenarios are the only place where lane selection of read data, A0 and byte-enable encoding per size, split strobe choice per lane, whole-cycle lengths and the address routing window are shown, because each needs an expected value derived from the request.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_STRB = 3'd2,
    PH_WAIT = 3'd3,
    PH_REL  = 3'd4
  } xb_phase_e;

  // high lane (bits 15:8) used by a word or by an odd byte
  function automatic logic lane_hi(input logic word, input logic a0);
    return word | a0;
  endfunction

  // low lane (bits 7:0) used by a word or by an even byte
  function automatic logic lane_lo(input logic word, input logic a0);
    return word | ~a0;
  endfunction

  // strobe lines are active in the strobe phase and in every wait phase
  function automatic logic in_strobe(input xb_phase_e ph);
    return (ph == PH_STRB) || (ph == PH_WAIT);
  endfunction

  function automatic logic in_bus(input xb_phase_e ph);
    return ph != PH_IDLE;
  endfunction

endpackage

// File: rtl/xbus_route.sv
`timescale 1ns/1ps
module xbus_route #(
  parameter int AW = 16,
  parameter logic [AW-1:0] LOCAL_END = 'h2000,
  parameter logic [AW-1:0] WIN_END   = 'h4000
) (
  input  logic [AW-1:0] addr,
  input  logic          ext_sel_n,
  output logic          offchip
);
  logic in_window;
  logic above_window;

  always_comb begin
    above_window = (addr >= WIN_END);
    in_window    = (addr >= LOCAL_END) && !above_window;
    offchip      = above_window || (in_window && !ext_sel_n);
  end
endmodule

// File: rtl/xbus_phase_fsm.sv
`timescale 1ns/1ps
module xbus_phase_fsm
  import xbus_pkg::*;
#(
  parameter int WLW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           rdy,
  input  logic [WLW-1:0] lim,
  output xb_phase_e      phase,
  output logic [WLW-1:0] wait_cnt,
  output logic           strobe_end
);
  logic extend;

  always_comb begin
    extend     = !rdy && (wait_cnt < lim);
    strobe_end = in_strobe(phase) && !extend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      wait_cnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase    <= PH_ADDR;
            wait_cnt <= '0;
          end
        end
        PH_ADDR: phase <= PH_STRB;
        PH_STRB, PH_WAIT: begin
          if (extend) begin
            phase    <= PH_WAIT;
            wait_cnt <= wait_cnt + WLW'(1);
          end else begin
            phase <= PH_REL;
          end
        end
        PH_REL:  phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_pins.sv
`timescale 1ns/1ps
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  xb_phase_e      phase,
  input  logic           adv_mode,
  input  logic           split,
  input  logic           write,
  input  logic           word,
  input  logic           fetch,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  ad_out,
  output logic           ad_oe,
  output logic           addr_strb,
  output logic           rd_n,
  output logic           wr_lo_n,
  output logic           bhe_wrh_n,
  output logic           inst
);
  localparam int LW = DW / 2;

  logic          busy;
  logic          strb;
  logic          hi;
  logic          lo;
  logic          addr_ph;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] lane_data;

  always_comb begin
    busy     = in_bus(phase);
    strb     = in_strobe(phase);
    addr_ph  = (phase == PH_ADDR);
    hi       = lane_hi(word, addr[0]);
    lo       = lane_lo(word, addr[0]);
    bus_addr = {addr[AW-1:1], addr[0] & ~word};
    lane_data = word ? wdata : {wdata[LW-1:0], wdata[LW-1:0]};

    addr_strb = adv_mode ? !(addr_ph || strb) : addr_ph;
    rd_n      = !(strb && !write);
    wr_lo_n   = !(strb && write && (!split || lo));
    bhe_wrh_n = split ? !(strb && write && hi) : !(busy && hi);
    inst      = busy && fetch && !write;
    ad_oe     = addr_ph || (write && (strb || phase == PH_REL));

    if (addr_ph)    ad_out = DW'(bus_addr);
    else if (ad_oe) ad_out = lane_data;
    else            ad_out = '0;
  end
endmodule

// File: rtl/xbus_capture.sv
`timescale 1ns/1ps
module xbus_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          word,
  input  logic          a0,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] rdata
);
  localparam int LW = DW / 2;

  function automatic logic [DW-1:0] pick_lane(input logic w, input logic odd,
                                              input logic [DW-1:0] bus);
    if (w)        return bus;
    else if (odd) return {{LW{1'b0}}, bus[DW-1:LW]};
    else          return {{LW{1'b0}}, bus[LW-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= pick_lane(word, a0, ad_in);
  end
endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WLW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic           req_word,
  input  logic           req_fetch,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           req_rdy,
  output logic           done,
  output logic           done_local,
  output logic [DW-1:0]  rdata,
  input  logic           cfg_adv_mode,
  input  logic           cfg_split_wr,
  input  logic [WLW-1:0] cfg_wait_lim,
  input  logic           ext_sel_n,
  input  logic           bus_rdy,
  input  logic [DW-1:0]  ad_in,
  output logic [DW-1:0]  ad_out,
  output logic           ad_oe,
  output logic           addr_strb,
  output logic           rd_n,
  output logic           wr_lo_n,
  output logic           bhe_wrh_n,
  output logic           inst
);
  xb_phase_e      phase;
  logic [WLW-1:0] wait_cnt;
  logic           strobe_end;
  logic           offchip;
  logic           accept;
  logic           start;

  // named events for the checker
  logic ph_idle, ph_addr, ph_strb, ph_wait, ph_rel;

  // request and configuration held for the cycle
  logic           wr_q, word_q, fetch_q, loc_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic           adv_q, split_q;
  logic [WLW-1:0] lim_q;

  always_comb begin
    ph_idle = (phase == PH_IDLE);
    ph_addr = (phase == PH_ADDR);
    ph_strb = (phase == PH_STRB);
    ph_wait = (phase == PH_WAIT);
    ph_rel  = (phase == PH_REL);
    accept  = req_valid && ph_idle;
    start   = accept && offchip;
  end

  xbus_route #(.AW(AW)) u_route (
    .addr      (req_addr),
    .ext_sel_n (ext_sel_n),
    .offchip   (offchip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      fetch_q <= 1'b0;
      loc_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      adv_q   <= 1'b0;
      split_q <= 1'b0;
      lim_q   <= '0;
    end else begin
      loc_q <= accept && !offchip;
      if (ph_idle) begin
        adv_q   <= cfg_adv_mode;
        split_q <= cfg_split_wr;
        lim_q   <= cfg_wait_lim;
      end
      if (start) begin
        wr_q    <= req_write;
        word_q  <= req_word;
        fetch_q <= req_fetch;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  xbus_phase_fsm #(.WLW(WLW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rdy        (bus_rdy),
    .lim        (lim_q),
    .phase      (phase),
    .wait_cnt   (wait_cnt),
    .strobe_end (strobe_end)
  );

  xbus_pins #(.AW(AW), .DW(DW)) u_pins (
    .phase     (phase),
    .adv_mode  (adv_q),
    .split     (split_q),
    .write     (wr_q),
    .word      (word_q),
    .fetch     (fetch_q),
    .addr      (addr_q),
    .wdata     (wdata_q),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .addr_strb (addr_strb),
    .rd_n      (rd_n),
    .wr_lo_n   (wr_lo_n),
    .bhe_wrh_n (bhe_wrh_n),
    .inst      (inst)
  );

  xbus_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (strobe_end && !wr_q),
    .word    (word_q),
    .a0      (addr_q[0]),
    .ad_in   (ad_in),
    .rdata   (rdata)
  );

  always_comb begin
    req_rdy    = ph_idle;
    done       = ph_rel || loc_q;
    done_local = loc_q;
  end
endmodule

// File: rtl/xbus_seq_chk.sv
`timescale 1ns/1ps
module xbus_seq_chk #(
  parameter int WLW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ph_idle,
  input logic           ph_addr,
  input logic           ph_strb,
  input logic           ph_wait,
  input logic           ph_rel,
  input logic [WLW-1:0] wait_cnt,
  input logic [WLW-1:0] lim_q,
  input logic           adv_q,
  input logic           split_q,
  input logic           wr_q,
  input logic           bus_rdy,
  input logic           addr_strb,
  input logic           rd_n,
  input logic           wr_lo_n,
  input logic           inst,
  input logic           ad_oe,
  input logic           done_local
);
  a_r2_addr_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ph_addr |=> ph_strb);

  a_r2_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_q && addr_strb) |=> !addr_strb);

  a_r3_valid_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_q && (ph_strb || ph_wait)) |-> !addr_strb);

  a_r4_read_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!wr_q && (ph_strb || ph_wait)));

  a_r6_write_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_q && wr_q && ph_strb) |-> !wr_lo_n);

  a_r8_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && (ph_strb || ph_wait || ph_rel)) |-> ad_oe);

  a_r9_inst_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_strb || ph_wait || ph_rel) |-> $stable(inst));

  a_r10_low_ready_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_strb || ph_wait) && !bus_rdy && (wait_cnt < lim_q)) |=> ph_wait);

  a_r10_high_ready_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_strb || ph_wait) && bus_rdy) |=> ph_rel);

  a_r11_wait_capped: assert property (@(posedge clk) disable iff (!rst_n)
    ph_wait |-> ((wait_cnt <= lim_q) && (wait_cnt != '0)));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ph_idle |-> (rd_n && wr_lo_n && !inst && !ad_oe));

  a_r13_local_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_local |-> (ph_idle && rd_n && wr_lo_n));
endmodule

bind xbus_seq xbus_seq_chk #(.WLW(WLW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ph_idle    (ph_idle),
  .ph_addr    (ph_addr),
  .ph_strb    (ph_strb),
  .ph_wait    (ph_wait),
  .ph_rel     (ph_rel),
  .wait_cnt   (wait_cnt),
  .lim_q      (lim_q),
  .adv_q      (adv_q),
  .split_q    (split_q),
  .wr_q       (wr_q),
  .bus_rdy    (bus_rdy),
  .addr_strb  (addr_strb),
  .rd_n       (rd_n),
  .wr_lo_n    (wr_lo_n),
  .inst       (inst),
  .ad_oe      (ad_oe),
  .done_local (done_local)
);

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb;
  logic        clk, rst_n;
  logic        req_valid, req_write, req_word, req_fetch;
  logic [15:0] req_addr, req_wdata;
  logic        req_rdy, done, done_local;
  logic [15:0] rdata;
  logic        cfg_adv_mode, cfg_split_wr;
  logic [1:0]  cfg_wait_lim;
  logic        ext_sel_n, bus_rdy;
  logic [15:0] ad_in, ad_out;
  logic        ad_oe, addr_strb, rd_n, wr_lo_n, bhe_wrh_n, inst;

  int checks = 0;
  int errors = 0;

  xbus_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_fetch(req_fetch), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rdy(req_rdy), .done(done), .done_local(done_local), .rdata(rdata),
    .cfg_adv_mode(cfg_adv_mode), .cfg_split_wr(cfg_split_wr),
    .cfg_wait_lim(cfg_wait_lim), .ext_sel_n(ext_sel_n), .bus_rdy(bus_rdy),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_strb(addr_strb),
    .rd_n(rd_n), .wr_lo_n(wr_lo_n), .bhe_wrh_n(bhe_wrh_n), .inst(inst)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  typedef struct packed {
    logic        wr;
    logic        word;
    logic        fetch;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [15:0] adin;
    logic [2:0]  lowk;
    logic        adv;
    logic        split;
    logic [1:0]  lim;
    logic [15:0] exp_rd;
    logic [2:0]  exp_waits;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 16'h8000, 16'h0000, 16'hBEEF, 3'd0, 1'b0, 1'b0, 2'd3, 16'hBEEF, 3'd0},
    '{1'b0, 1'b0, 1'b0, 16'h8002, 16'h0000, 16'h12A5, 3'd1, 1'b1, 1'b0, 2'd3, 16'h00A5, 3'd1},
    '{1'b0, 1'b0, 1'b0, 16'h8003, 16'h0000, 16'h12A5, 3'd2, 1'b0, 1'b0, 2'd1, 16'h0012, 3'd1},
    '{1'b1, 1'b1, 1'b0, 16'h9000, 16'hCAFE, 16'h0000, 3'd0, 1'b0, 1'b0, 2'd0, 16'h0000, 3'd0},
    '{1'b1, 1'b0, 1'b0, 16'h9004, 16'h0033, 16'h0000, 3'd3, 1'b1, 1'b1, 2'd3, 16'h0000, 3'd3},
    '{1'b1, 1'b0, 1'b1, 16'h9005, 16'h0044, 16'h0000, 3'd0, 1'b0, 1'b1, 2'd2, 16'h0000, 3'd0},
    '{1'b1, 1'b1, 1'b0, 16'h9006, 16'h1357, 16'h0000, 3'd7, 1'b0, 1'b1, 2'd2, 16'h0000, 3'd2},
    '{1'b0, 1'b1, 1'b1, 16'h4000, 16'h0000, 16'h0F0F, 3'd7, 1'b1, 1'b0, 2'd3, 16'h0F0F, 3'd3}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_ext(input vec_t v);
    int n_cyc = 0, n_ale = 0, n_adv = 0, n_strb = 0, n_rd = 0;
    int n_wrl = 0, n_wrh = 0, n_bhe = 0, inst_bad = 0, data_bad = 0;
    logic a0_seen = 1'b1;
    logic done_seen = 1'b0;
    logic loc_seen = 1'b1;
    logic [15:0] rd_got = '0;
    logic hi, lo, exp_inst, strb_act;
    logic [15:0] exp_w;
    hi = v.word | v.addr[0];
    lo = v.word | ~v.addr[0];
    exp_inst = v.fetch & ~v.wr;
    exp_w = v.word ? v.wdata : {v.wdata[7:0], v.wdata[7:0]};

    @(negedge clk);
    cfg_adv_mode = v.adv; cfg_split_wr = v.split; cfg_wait_lim = v.lim;
    ad_in = v.adin; bus_rdy = 1'b1;
    req_write = v.wr; req_word = v.word; req_fetch = v.fetch;
    req_addr = v.addr; req_wdata = v.wdata; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 40 && !done_seen; t++) begin
      n_cyc++;
      if (t == 0) a0_seen = ad_out[0];
      strb_act = v.wr ? (!wr_lo_n || (v.split && !bhe_wrh_n)) : !rd_n;
      if (strb_act) n_strb++;
      if (!rd_n) n_rd++;
      if (!wr_lo_n) n_wrl++;
      if (v.split) begin if (!bhe_wrh_n) n_wrh++; end
      else begin if (!bhe_wrh_n) n_bhe++; end
      if (v.adv) begin if (!addr_strb) n_adv++; end
      else begin if (addr_strb) n_ale++; end
      if (inst !== exp_inst) inst_bad++;
      if (t > 0) begin
        if (v.wr && (ad_oe !== 1'b1 || ad_out !== exp_w)) data_bad++;
        if (!v.wr && ad_oe !== 1'b0) data_bad++;
      end
      if (done) begin
        done_seen = 1'b1;
        rd_got = rdata;
        loc_seen = done_local;
      end else begin
        bus_rdy = (n_strb > int'(v.lowk));
        @(negedge clk);
      end
    end
    bus_rdy = 1'b1;

    check("R2 done reached", done_seen, 1);
    check("R2 cycle length", n_cyc, 3 + int'(v.exp_waits));
    check("R13 off-chip not local", loc_seen, 0);
    if (v.adv) check("R3 valid low width", n_adv, 2 + int'(v.exp_waits));
    else       check("R2 latch pulse width", n_ale, 1);
    check("R10 R11 strobe clocks", n_strb, 1 + int'(v.exp_waits));
    check("R5 A0 in address clock", a0_seen, v.word ? 1'b0 : v.addr[0]);
    if (!v.split) check("R5 high enable clocks", n_bhe, hi ? 3 + int'(v.exp_waits) : 0);
    check("R9 fetch indicator", inst_bad, 0);
    if (!v.wr) begin
      check("R4 read strobe clocks", n_rd, 1 + int'(v.exp_waits));
      check("R4 read data lane", rd_got, v.exp_rd);
      check("R4 bus released on read", data_bad, 0);
    end else begin
      check("R8 write data held", data_bad, 0);
      check("R4 no read strobe on write", n_rd, 0);
      if (!v.split) check("R6 combined write strobe", n_wrl, 1 + int'(v.exp_waits));
      else begin
        check("R7 low lane strobe", n_wrl, lo ? 1 + int'(v.exp_waits) : 0);
        check("R7 high lane strobe", n_wrh, hi ? 1 + int'(v.exp_waits) : 0);
      end
    end
  endtask

  task automatic run_local(input logic [15:0] addr);
    @(negedge clk);
    cfg_adv_mode = 1'b0; cfg_split_wr = 1'b0;
    req_write = 1'b0; req_word = 1'b1; req_fetch = 1'b1;
    req_addr = addr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R13 local done", {done, done_local}, 2'b11);
    check("R13 local bus quiet", {rd_n, wr_lo_n, bhe_wrh_n, addr_strb, inst, ad_oe}, 6'b111000);
    @(negedge clk);
    check("R13 local done single clock", {done, done_local}, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t vx;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_fetch = 1'b0; req_addr = '0; req_wdata = '0;
    cfg_adv_mode = 1'b0; cfg_split_wr = 1'b0; cfg_wait_lim = 2'd0;
    ext_sel_n = 1'b1; bus_rdy = 1'b1; ad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset strobes", {rd_n, wr_lo_n, bhe_wrh_n, addr_strb}, 4'b1110);
    check("R1 reset outputs", {inst, ad_oe, done, done_local, req_rdy}, 5'b00001);
    check("R1 reset rdata", rdata, 0);

    // R12: ready toggling while idle
    cfg_adv_mode = 1'b1; cfg_split_wr = 1'b1;
    for (int k = 0; k < 6; k++) begin
      bus_rdy = k[0];
      @(negedge clk);
      check("R12 idle ignores ready",
            {rd_n, wr_lo_n, bhe_wrh_n, addr_strb, inst, ad_oe, done}, 7'b1111000);
    end
    bus_rdy = 1'b1;

    for (int i = 0; i < NV; i++) run_ext(VECS[i]);

    // R13 routing window
    ext_sel_n = 1'b0;
    run_local(16'h0100);
    run_local(16'h1FFF);
    vx = '{1'b0, 1'b1, 1'b0, 16'h2100, 16'h0000, 16'h5A5A, 3'd0, 1'b0, 1'b0, 2'd3, 16'h5A5A, 3'd0};
    run_ext(vx);
    vx = '{1'b0, 1'b0, 1'b0, 16'h3FFF, 16'h0000, 16'h7700, 3'd0, 1'b0, 1'b0, 2'd3, 16'h0077, 3'd0};
    run_ext(vx);
    ext_sel_n = 1'b1;
    run_local(16'h2100);
    run_local(16'h3FFF);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule